// File: doc/BRIEF.md
# Min/max peak detecting decimator

This block sits between an ADC and a capture memory. It takes one unsigned sample per clock, qualified by a valid strobe, and reduces the stream by a programmable ratio N. Slow time bases need this because the memory cannot hold every raw sample. Each group of N accepted samples is one interval.

In decimate mode each interval yields one output beat, which carries the first sample of that interval. In peak mode each interval yields two beats on consecutive cycles: the smallest and then the largest raw sample seen in the interval. Because of this, a narrow glitch in the raw stream still reaches memory at any ratio.

A flag marks the second beat of a pair. The mode and the ratio are sampled only when an interval starts, so a change on those inputs never splits an interval. A synchronous clear drops any partial interval and starts afresh.

Top module: `peak_decimator`

## Requirements
- R1: After reset, or in the cycle after `clr` is high, `out_valid` is low. `clr` discards the samples of a partial interval, so the next accepted sample starts a new interval.
- R2: In decimate mode (`peak_mode`=0) exactly one beat is produced for every N accepted samples. Its `out_data` is the first sample of the interval and its `out_last` is 0.
- R3: In peak mode (`peak_mode`=1) every interval produces two beats on consecutive cycles. The first has `out_last`=0 and the second has `out_last`=1.
- R4: In peak mode the first beat of a pair is the minimum and the second beat is the maximum of all samples accepted in the interval. The tracker starts each interval at min 8'hFF and max 8'h00.
- R5: With N=1, decimate mode passes every accepted sample through. Peak mode gives a pair whose min and max both equal that sample.
- R6: A `ratio` value of 0 behaves exactly like a ratio of 1.
- R7: A cycle with `in_valid` low neither counts toward the interval nor affects the min, the max or the kept sample.
- R8: `peak_mode` and `ratio` are taken when the first sample of an interval is accepted. Changes on them during the interval have no effect until the next interval starts.
- R9: The first (or only) beat of an interval appears in the cycle right after the clock edge that accepts the interval's last sample. At no other time is a first beat produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the interval state and the output |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW | Unsigned ADC code |
| peak_mode | input | 1 | 0 selects decimate, 1 selects min/max pairs |
| ratio | input | RW | Decimation ratio N (0 acts as 1) |
| out_valid | output | 1 | Output beat present |
| out_data | output | DW | Decimated sample, or min/max value |
| out_last | output | 1 | High on the max beat of a pair |

## Verification
The checker assumes the input never closes an interval in the cycle when the max beat of a pair is still waiting to go out. This case arises only with an effective ratio of 1 right after a peak-mode interval closes. The checker flags any violation. The stimulus keeps within this limit by dropping `in_valid` for that one cycle whenever the next sample would close an interval. It also asserts `clr` only when no max beat is pending. Within those limits the random phase mixes ratios of 0, 1, small values and larger values, both modes, idle cycles and mid-interval setting changes.

// File: rtl/pkdec_pkg.sv
package pkdec_pkg;
   typedef enum logic {
      MODE_DECIM = 1'b0,
      MODE_PEAK  = 1'b1
   } pd_mode_e;
endpackage

// File: rtl/pkdec_interval.sv
module pkdec_interval
   import pkdec_pkg::*;
#(
   parameter int RW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          in_valid,
   input  logic [RW-1:0] ratio_in,
   input  logic          mode_in,
   output logic          first,
   output logic          close,
   output pd_mode_e      mode_eff
);
   localparam logic [RW-1:0] ONE = {{(RW-1){1'b0}}, 1'b1};

   logic [RW-1:0] cnt_q;
   logic [RW-1:0] ratio_q;
   pd_mode_e      mode_q;
   logic [RW-1:0] ratio_live;
   logic [RW-1:0] ratio_eff;
   logic [RW-1:0] cnt_nxt;

   assign first      = (cnt_q == '0);
   assign ratio_live = (ratio_in == '0) ? ONE : ratio_in;
   assign ratio_eff  = first ? ratio_live : ratio_q;
   assign mode_eff   = first ? pd_mode_e'(mode_in) : mode_q;
   assign cnt_nxt    = cnt_q + ONE;
   assign close      = in_valid && (cnt_nxt == ratio_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ratio_q <= ONE;
         mode_q  <= MODE_DECIM;
      end else if (clr) begin
         cnt_q   <= '0;
      end else if (in_valid) begin
         if (first) begin
            ratio_q <= ratio_live;
            mode_q  <= pd_mode_e'(mode_in);
         end
         cnt_q <= close ? '0 : cnt_nxt;
      end
   end
endmodule

// File: rtl/pkdec_track.sv
module pkdec_track #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          first,
   input  logic [DW-1:0] in_data,
   output logic [DW-1:0] min_nxt,
   output logic [DW-1:0] max_nxt,
   output logic [DW-1:0] keep_nxt
);
   localparam logic [DW-1:0] MIN_SEED = {DW{1'b1}};
   localparam logic [DW-1:0] MAX_SEED = {DW{1'b0}};

   logic [DW-1:0] run_min_q;
   logic [DW-1:0] run_max_q;
   logic [DW-1:0] keep_q;
   logic [DW-1:0] min_base;
   logic [DW-1:0] max_base;

   assign min_base = first ? MIN_SEED : run_min_q;
   assign max_base = first ? MAX_SEED : run_max_q;
   assign min_nxt  = (in_data < min_base) ? in_data : min_base;
   assign max_nxt  = (in_data > max_base) ? in_data : max_base;
   assign keep_nxt = first ? in_data : keep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_min_q <= MIN_SEED;
         run_max_q <= MAX_SEED;
         keep_q    <= '0;
      end else if (in_valid) begin
         run_min_q <= min_nxt;
         run_max_q <= max_nxt;
         keep_q    <= keep_nxt;
      end
   end
endmodule

// File: rtl/pkdec_emit.sv
module pkdec_emit
   import pkdec_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          close,
   input  pd_mode_e      mode_eff,
   input  logic [DW-1:0] min_nxt,
   input  logic [DW-1:0] max_nxt,
   input  logic [DW-1:0] keep_nxt,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_last,
   output logic          pend
);
   logic [DW-1:0] pend_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         out_last    <= 1'b0;
         pend        <= 1'b0;
         pend_data_q <= '0;
      end else if (clr) begin
         out_valid   <= 1'b0;
         out_last    <= 1'b0;
         pend        <= 1'b0;
      end else if (close) begin
         out_valid <= 1'b1;
         out_last  <= 1'b0;
         if (mode_eff == MODE_PEAK) begin
            out_data    <= min_nxt;
            pend        <= 1'b1;
            pend_data_q <= max_nxt;
         end else begin
            out_data <= keep_nxt;
            pend     <= 1'b0;
         end
      end else if (pend) begin
         out_valid <= 1'b1;
         out_last  <= 1'b1;
         out_data  <= pend_data_q;
         pend      <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end
   end
endmodule

// File: rtl/peak_decimator.sv
module peak_decimator
   import pkdec_pkg::*;
#(
   parameter int DW = 8,
   parameter int RW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          peak_mode,
   input  logic [RW-1:0] ratio,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_last
);
   generate
      if (DW < 2 || DW > 32) begin : g_bad_dw
         $error("peak_decimator: DW out of range");
      end
      if (RW < 1 || RW > 32) begin : g_bad_rw
         $error("peak_decimator: RW out of range");
      end
   endgenerate

   logic          first_w;
   logic          close_w;
   logic          pend_w;
   pd_mode_e      mode_w;
   logic [DW-1:0] min_w;
   logic [DW-1:0] max_w;
   logic [DW-1:0] keep_w;

   pkdec_interval #(.RW(RW)) u_interval (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .in_valid (in_valid),
      .ratio_in (ratio),
      .mode_in  (peak_mode),
      .first    (first_w),
      .close    (close_w),
      .mode_eff (mode_w)
   );

   pkdec_track #(.DW(DW)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid && !clr),
      .first    (first_w),
      .in_data  (in_data),
      .min_nxt  (min_w),
      .max_nxt  (max_w),
      .keep_nxt (keep_w)
   );

   pkdec_emit #(.DW(DW)) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .close     (close_w),
      .mode_eff  (mode_w),
      .min_nxt   (min_w),
      .max_nxt   (max_w),
      .keep_nxt  (keep_w),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_last  (out_last),
      .pend      (pend_w)
   );
endmodule

// File: rtl/pkdec_chk.sv
module pkdec_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clr,
   input logic          in_valid,
   input logic          close_w,
   input logic          pend_w,
   input logic          out_valid,
   input logic          out_last,
   input logic [DW-1:0] out_data
);
   // R3
   max_follows_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> $past(out_valid && !out_last));

   // R4
   max_not_below_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (out_data >= $past(out_data)));

   // R9
   first_beat_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> $past(in_valid && !clr));

   // R1
   clear_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !out_valid);

   // R3
   pending_max_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_w && !clr) |=> (out_valid && out_last));

   // R3
   no_beat_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_w |-> !(close_w && !clr));
endmodule

bind peak_decimator pkdec_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .in_valid  (in_valid),
   .close_w   (close_w),
   .pend_w    (pend_w),
   .out_valid (out_valid),
   .out_last  (out_last),
   .out_data  (out_data)
);

// File: tb/sim_peak_decimator.sv
`timescale 1ns/1ps
module sim_peak_decimator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        peak_mode = 1'b0;
   logic [15:0] ratio = 16'd1;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_last;

   always #2.5 clk = ~clk;

   peak_decimator u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
      .in_data(in_data), .peak_mode(peak_mode), .ratio(ratio),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
   );

   int checks = 0;
   int errors = 0;
   string tag = "R1";

   logic [8:0] expq[$];
   int         m_cnt = 0;
   int         m_ratio = 1;
   bit         m_mode = 0;
   logic [7:0] m_min, m_max, m_keep;
   bit         pend_prev = 0;

   function automatic int eff_ratio(logic [15:0] r);
      return (r == 16'd0) ? 1 : int'(r);
   endfunction

   function automatic bit would_close(logic [15:0] r);
      return ((m_cnt == 0) ? eff_ratio(r) : m_ratio) == m_cnt + 1;
   endfunction

   task automatic check(bit ok, string t, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
      end
   endtask

   task automatic step(bit v, logic [7:0] d, bit m, logic [15:0] r);
      bit closed = 0;
      bit peak_close = 0;
      logic [8:0] e;
      if (v && pend_prev && would_close(r)) v = 0;
      in_valid = v; in_data = d; peak_mode = m; ratio = r; clr = 0;
      if (v) begin
         if (m_cnt == 0) begin
            m_ratio = eff_ratio(r); m_mode = m;
            m_min = 8'hFF; m_max = 8'h00; m_keep = d;
         end
         if (d < m_min) m_min = d;
         if (d > m_max) m_max = d;
         m_cnt++;
         if (m_cnt == m_ratio) begin
            closed = 1; m_cnt = 0;
            if (m_mode) begin
               expq.push_back({1'b0, m_min});
               expq.push_back({1'b1, m_max});
               peak_close = 1;
            end else begin
               expq.push_back({1'b0, m_keep});
            end
         end
      end
      @(negedge clk);
      check(out_valid == (closed || pend_prev), "R9 out_valid timing",
            out_valid, closed || pend_prev);
      if (out_valid) begin
         if (expq.size() == 0) begin
            check(0, {tag, " unexpected beat"}, {out_last, out_data}, 0);
         end else begin
            e = expq.pop_front();
            check({out_last, out_data} == e, {tag, " beat"}, {out_last, out_data}, e);
         end
      end
      pend_prev = peak_close;
   endtask

   task automatic do_clear();
      while (pend_prev) step(0, 8'h00, peak_mode, ratio);
      in_valid = 1; in_data = 8'h00; clr = 1;
      m_cnt = 0;
      @(negedge clk);
      check(out_valid == 0, "R1 clear drops output", out_valid, 0);
      clr = 0; in_valid = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      @(negedge clk);
      check(out_valid == 0, "R1 reset out_valid", out_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      check(out_valid == 0, "R1 after reset", out_valid, 0);

      tag = "R2";
      for (int i = 0; i < 12; i++) step(1, 8'(8'h10 + i), 0, 16'd4);

      tag = "R4";
      step(1, 8'h80, 1, 16'd5); step(1, 8'h03, 1, 16'd5); step(1, 8'hF0, 1, 16'd5);
      step(1, 8'h40, 1, 16'd5); step(1, 8'h41, 1, 16'd5);
      step(0, 0, 1, 16'd5); step(0, 0, 1, 16'd5);
      for (int i = 0; i < 5; i++) step(1, 8'hFF, 1, 16'd5);
      step(0, 0, 1, 16'd5);

      tag = "R5";
      for (int i = 0; i < 6; i++) step(1, 8'(i * 37), 0, 16'd1);
      for (int i = 0; i < 6; i++) step(1, 8'(i * 29 + 1), 1, 16'd1);

      tag = "R6";
      for (int i = 0; i < 4; i++) step(1, 8'(8'hA0 + i), 0, 16'd0);
      for (int i = 0; i < 4; i++) step(1, 8'(8'h50 + i), 1, 16'd0);

      tag = "R7";
      step(0, 0, 0, 16'd3);
      step(1, 8'h22, 0, 16'd3); step(0, 8'h00, 0, 16'd3);
      step(1, 8'h33, 0, 16'd3); step(0, 8'hFF, 0, 16'd3); step(1, 8'h44, 0, 16'd3);
      step(1, 8'h60, 1, 16'd3); step(0, 8'h00, 1, 16'd3); step(1, 8'h61, 1, 16'd3);
      step(0, 8'hFF, 1, 16'd3); step(1, 8'h62, 1, 16'd3); step(0, 0, 1, 16'd3);

      tag = "R8";
      step(1, 8'h11, 0, 16'd4); step(1, 8'h01, 1, 16'd1);
      step(1, 8'hEE, 1, 16'd2); step(1, 8'h77, 1, 16'd9);
      step(1, 8'h90, 1, 16'd2); step(1, 8'h05, 0, 16'd7);
      step(0, 0, 0, 16'd7);

      tag = "R1";
      step(1, 8'h01, 0, 16'd3); step(1, 8'h02, 0, 16'd3);
      do_clear();
      step(1, 8'hC1, 0, 16'd2); step(1, 8'hC2, 0, 16'd2);

      tag = "RND";
      begin
         bit         rm = 0;
         logic [15:0] rr = 16'd3;
         for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
               rm = $urandom_range(0, 1);
               case ($urandom_range(0, 5))
                  0: rr = 16'd0;
                  1: rr = 16'd1;
                  2: rr = 16'd2;
                  3: rr = 16'd7;
                  4: rr = 16'd16;
                  default: rr = 16'($urandom_range(3, 40));
               endcase
            end
            if ($urandom_range(0, 199) == 0) do_clear();
            tag = rm ? "R4 random" : "R2 random";
            step($urandom_range(0, 4) != 0, 8'($urandom), rm, rr);
         end
      end
      for (int i = 0; i < 3; i++) step(0, 0, 0, 16'd1);
      check(expq.size() == 0, "R3 all expected beats seen", expq.size(), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule